// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This block sits in front of a page-write controller and decides whether host write cycles may load a page. It watches every host write (an address plus a data byte) and compares the stream against two fixed command sequences. A three-write unlock sequence opens a single page-load cycle. A six-write disable sequence turns protection off. The protection flag starts out set and survives the block's reset, which models a flag that is kept across power cycles.

While protection is set, the load permit stays closed until a full unlock sequence arrives. It then stays open until the page controller reports that the load cycle has ended. Issuing the unlock sequence while unprotected sets protection again and opens that same load cycle. While unprotected, the permit is always open, so plain writes go straight into a load cycle. All command addresses and data codes are parameters.

Top module: `wp_seq_guard`

## Requirements
- R1: Before any write, `prot_en` reads 1 and `load_permit` reads 0.
- R2: Asserting `rst_n` low never changes `prot_en`, whether it is 1 or 0.
- R3: While `prot_en` is 1 and no load cycle is open, writes that do not form the unlock sequence leave `load_permit` at 0.
- R4: While protected, the writes 0xAA to 0x5555, 0x55 to 0x2AAA and 0xA0 to 0x5555 on consecutive write cycles raise `load_permit` in the cycle after the third write, and `prot_en` stays 1.
- R5: An open load cycle keeps `load_permit` at 1 through any writes and idle cycles. It drops to 0 in the cycle after `load_done` is 1.
- R6: A write that does not match the next expected step returns the matcher to its start. If that write equals the first step (0xAA to 0x5555), it counts as step one.
- R7: The writes 0xAA to 0x5555, 0x55 to 0x2AAA, 0x80 to 0x5555, 0xAA to 0x5555, 0x55 to 0x2AAA and 0x20 to 0x5555 clear `prot_en` in the cycle after the sixth write.
- R8: While `prot_en` is 0, `load_permit` is 1 in every cycle, including after `load_done`.
- R9: The unlock sequence issued while unprotected sets `prot_en` in the cycle after its third write. It also opens a load cycle, which then closes on `load_done`.
- R10: A reset closes any open load cycle and discards a partly received sequence.
- R11: Cycles with `wr_valid` at 0 are not writes. They neither advance nor break a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; it does not touch the protection flag |
| wr_valid | input | 1 | A host write occurs in this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data byte |
| load_done | input | 1 | The page controller ends the current load cycle |
| load_permit | output | 1 | Page loads are allowed |
| prot_en | output | 1 | Protection is enabled |

## Verification
The unlock sequence is driven clean, and with a repeated first step that must restart the count instead of breaking it. It is also driven with a wrong third code, with idle gaps inside it, and with a reset in the middle. Together these separate a correct restart rule from one that ignores mismatches, and show that idle cycles and resets are handled as the requirements state. The disable sequence, which shares its first two steps with the unlock sequence, shows that the two matchers track the stream independently. Resets applied in both protection states show that the flag persists across reset while the load cycle does not.

// File: rtl/wp_pkg.sv
package wp_pkg;

  localparam int unsigned BYTE_W = 8;

  // Step counter update: advance on a match of the expected step,
  // otherwise restart, counting the write as step one if it matches step zero.
  function automatic int unsigned step_next(input int unsigned cur,
                                            input logic hit_cur,
                                            input logic hit_first);
    if (hit_cur)        return cur + 1;
    else if (hit_first) return 1;
    else                return 0;
  endfunction

endpackage

// File: rtl/seq_matcher.sv
module seq_matcher #(
  parameter int unsigned LEN    = 3,
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8,
  parameter logic [LEN*ADDR_W-1:0] ADDRS = '0,
  parameter logic [LEN*DATA_W-1:0] DATAS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clear,
  output logic              hit
);
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] step_q;
  logic          match_cur;
  logic          match_first;

  assign match_cur   = (wr_addr == ADDRS[step_q*ADDR_W +: ADDR_W]) &&
                       (wr_data == DATAS[step_q*DATA_W +: DATA_W]);
  assign match_first = (wr_addr == ADDRS[ADDR_W-1:0]) &&
                       (wr_data == DATAS[DATA_W-1:0]);
  assign hit = rst_n && wr_valid && match_cur && (step_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear)
      step_q <= '0;
    else if (wr_valid)
      step_q <= CW'(wp_pkg::step_next(int'(step_q), match_cur, match_first));
  end

  // R6: a write matching neither the expected step nor step zero restarts
  p_mismatch_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !match_cur && !match_first && !clear) |=> (step_q == '0));

  // R11: idle cycles leave the progress untouched
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid && !clear) |=> $stable(step_q));

endmodule

// File: rtl/load_window.sv
module load_window (
  input  logic clk,
  input  logic rst_n,
  input  logic open_i,
  input  logic close_i,
  input  logic drop_i,
  output logic window_o
);
  logic win_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 win_q <= 1'b0;
    else if (open_i)            win_q <= 1'b1;
    else if (close_i || drop_i) win_q <= 1'b0;
  end

  assign window_o = win_q;

  // R4: the window only opens on a completed unlock
  p_open_needs_unlock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_q) |-> $past(open_i));

  // R5: the end of a load cycle closes the window
  p_close_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q && close_i && !open_i) |=> !win_q);

endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = wp_pkg::BYTE_W,
  parameter logic [3*ADDR_W-1:0] UNL_ADDRS = {ADDR_W'(15'h5555), ADDR_W'(15'h2AAA), ADDR_W'(15'h5555)},
  parameter logic [3*DATA_W-1:0] UNL_DATAS = {DATA_W'(8'hA0), DATA_W'(8'h55), DATA_W'(8'hAA)},
  parameter logic [6*ADDR_W-1:0] DIS_ADDRS = {ADDR_W'(15'h5555), ADDR_W'(15'h2AAA), ADDR_W'(15'h5555),
                                              ADDR_W'(15'h5555), ADDR_W'(15'h2AAA), ADDR_W'(15'h5555)},
  parameter logic [6*DATA_W-1:0] DIS_DATAS = {DATA_W'(8'h20), DATA_W'(8'h55), DATA_W'(8'hAA),
                                              DATA_W'(8'h80), DATA_W'(8'h55), DATA_W'(8'hAA)}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load_done,
  output logic              load_permit,
  output logic              prot_en
);
  // Named internal events
  logic unl_hit;
  logic dis_hit;
  logic any_hit;
  logic window;

  // Protection flag: set out of the box, no reset branch (persists).
  logic prot_q = 1'b1;

  assign any_hit = unl_hit || dis_hit;

  seq_matcher #(
    .LEN(3), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ADDRS(UNL_ADDRS), .DATAS(UNL_DATAS)
  ) unlock_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .clear(any_hit), .hit(unl_hit)
  );

  seq_matcher #(
    .LEN(6), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ADDRS(DIS_ADDRS), .DATAS(DIS_DATAS)
  ) disable_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .clear(any_hit), .hit(dis_hit)
  );

  load_window win_i (
    .clk(clk), .rst_n(rst_n),
    .open_i(unl_hit), .close_i(load_done), .drop_i(dis_hit),
    .window_o(window)
  );

  always_ff @(posedge clk) begin
    if (unl_hit)      prot_q <= 1'b1;
    else if (dis_hit) prot_q <= 1'b0;
  end

  assign prot_en     = prot_q;
  assign load_permit = !prot_q || window;

  // R2: reset leaves the protection flag alone
  p_reset_keeps_prot_r2: assert property (@(posedge clk)
    !rst_n |=> (prot_q == $past(prot_q)));

  // R7: protection only drops after a completed disable sequence
  p_prot_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_q) |-> $past(dis_hit));

  // R9: protection only rises after a completed unlock sequence
  p_prot_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_q) |-> $past(unl_hit));

  // R8: unprotected means loads are always permitted
  p_unprot_permit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_q |-> load_permit);

  // R3: protected without a window keeps loads blocked next cycle unless unlocked
  p_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_q && !load_permit && !unl_hit && !dis_hit) |=> !load_permit);

endmodule

// File: tb/wp_seq_guard_tb_top.sv
module wp_seq_guard_tb_top;
  localparam int unsigned AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          load_done = 1'b0;
  logic          load_permit;
  logic          prot_en;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    bit    permit;
    bit    prot;
    string req;
  } exp_t;

  exp_t sb_q[$];

  always #5 clk = ~clk;

  wp_seq_guard dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .load_done(load_done),
    .load_permit(load_permit), .prot_en(prot_en)
  );

  // Monitor: compare outputs at the falling edge after each driven cycle
  always @(negedge clk) begin
    exp_t e;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      checks++;
      if (load_permit !== e.permit) begin
        errors++;
        $display("FAIL %s load_permit actual=%0b expected=%0b", e.req, load_permit, e.permit);
      end
      checks++;
      if (prot_en !== e.prot) begin
        errors++;
        $display("FAIL %s prot_en actual=%0b expected=%0b", e.req, prot_en, e.prot);
      end
    end
  end

  // Driver: one clock cycle of stimulus plus the expected outputs after it
  task automatic cyc(input bit v, input logic [AW-1:0] a, input logic [7:0] d,
                     input bit done, input bit rst, input bit ep, input bit epr,
                     input string req);
    exp_t e;
    @(negedge clk);
    wr_valid  = v;
    wr_addr   = a;
    wr_data   = d;
    load_done = done;
    rst_n     = !rst;
    @(posedge clk);
    #1;
    e.permit = ep;
    e.prot   = epr;
    e.req    = req;
    sb_q.push_back(e);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d,
                    input bit ep, input bit epr, input string req);
    cyc(1'b1, a, d, 1'b0, 1'b0, ep, epr, req);
  endtask

  task automatic idle(input bit ep, input bit epr, input string req);
    cyc(1'b0, '0, '0, 1'b0, 1'b0, ep, epr, req);
  endtask

  task automatic done_c(input bit ep, input bit epr, input string req);
    cyc(1'b0, '0, '0, 1'b1, 1'b0, ep, epr, req);
  endtask

  task automatic rst_c(input bit ep, input bit epr, input string req);
    cyc(1'b0, '0, '0, 1'b0, 1'b1, ep, epr, req);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    // R1: power-up state, held in reset
    for (int i = 0; i < 3; i++) rst_c(1'b0, 1'b1, "R1");
    idle(1'b0, 1'b1, "R1");

    // R3: plain writes while protected
    wr(18'h01234, 8'h11, 1'b0, 1'b1, "R3");
    wr(18'h05555, 8'h55, 1'b0, 1'b1, "R3");

    // R4: clean unlock
    wr(18'h05555, 8'hAA, 1'b0, 1'b1, "R4");
    wr(18'h02AAA, 8'h55, 1'b0, 1'b1, "R4");
    wr(18'h05555, 8'hA0, 1'b1, 1'b1, "R4");
    // R5: window stays open through loads and idle, closes on done
    wr(18'h00100, 8'h3C, 1'b1, 1'b1, "R5");
    idle(1'b1, 1'b1, "R5");
    done_c(1'b0, 1'b1, "R5");
    idle(1'b0, 1'b1, "R5");

    // R6: repeated first step counts as step one
    wr(18'h05555, 8'hAA, 1'b0, 1'b1, "R6");
    wr(18'h05555, 8'hAA, 1'b0, 1'b1, "R6");
    wr(18'h02AAA, 8'h55, 1'b0, 1'b1, "R6");
    wr(18'h05555, 8'hA0, 1'b1, 1'b1, "R6");
    done_c(1'b0, 1'b1, "R6");

    // R6: wrong third code breaks the sequence
    wr(18'h05555, 8'hAA, 1'b0, 1'b1, "R6");
    wr(18'h02AAA, 8'h55, 1'b0, 1'b1, "R6");
    wr(18'h05555, 8'h77, 1'b0, 1'b1, "R6");
    wr(18'h05555, 8'hA0, 1'b0, 1'b1, "R6");

    // R11: invalid cycle carrying step two is not a write
    wr(18'h05555, 8'hAA, 1'b0, 1'b1, "R11");
    cyc(1'b0, 18'h02AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b1, "R11");
    wr(18'h05555, 8'hA0, 1'b0, 1'b1, "R11");
    // R11: idle gaps inside a valid sequence do not break it
    wr(18'h05555, 8'hAA, 1'b0, 1'b1, "R11");
    idle(1'b0, 1'b1, "R11");
    wr(18'h02AAA, 8'h55, 1'b0, 1'b1, "R11");
    idle(1'b0, 1'b1, "R11");
    wr(18'h05555, 8'hA0, 1'b1, 1'b1, "R11");
    done_c(1'b0, 1'b1, "R11");

    // R10: reset inside a sequence discards progress
    wr(18'h05555, 8'hAA, 1'b0, 1'b1, "R10");
    wr(18'h02AAA, 8'h55, 1'b0, 1'b1, "R10");
    rst_c(1'b0, 1'b1, "R10");
    wr(18'h05555, 8'hA0, 1'b0, 1'b1, "R10");
    // R10: reset closes an open window
    wr(18'h05555, 8'hAA, 1'b0, 1'b1, "R10");
    wr(18'h02AAA, 8'h55, 1'b0, 1'b1, "R10");
    wr(18'h05555, 8'hA0, 1'b1, 1'b1, "R10");
    rst_c(1'b0, 1'b1, "R10");
    idle(1'b0, 1'b1, "R10");

    // R7: six-write disable
    wr(18'h05555, 8'hAA, 1'b0, 1'b1, "R7");
    wr(18'h02AAA, 8'h55, 1'b0, 1'b1, "R7");
    wr(18'h05555, 8'h80, 1'b0, 1'b1, "R7");
    wr(18'h05555, 8'hAA, 1'b0, 1'b1, "R7");
    wr(18'h02AAA, 8'h55, 1'b0, 1'b1, "R7");
    wr(18'h05555, 8'h20, 1'b1, 1'b0, "R7");

    // R8: unprotected permit always open
    wr(18'h00200, 8'h01, 1'b1, 1'b0, "R8");
    idle(1'b1, 1'b0, "R8");
    done_c(1'b1, 1'b0, "R8");
    idle(1'b1, 1'b0, "R8");

    // R2: reset while unprotected keeps the flag clear
    rst_c(1'b1, 1'b0, "R2");
    rst_c(1'b1, 1'b0, "R2");
    idle(1'b1, 1'b0, "R2");

    // R9: unlock while unprotected re-enables and opens a window
    wr(18'h05555, 8'hAA, 1'b1, 1'b0, "R9");
    wr(18'h02AAA, 8'h55, 1'b1, 1'b0, "R9");
    wr(18'h05555, 8'hA0, 1'b1, 1'b1, "R9");
    wr(18'h00300, 8'h42, 1'b1, 1'b1, "R9");
    done_c(1'b0, 1'b1, "R9");

    // R2: reset while protected keeps the flag set
    rst_c(1'b0, 1'b1, "R2");
    idle(1'b0, 1'b1, "R2");

    idle(1'b0, 1'b1, "R2");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

  // Watchdog
  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

endmodule